// File: doc/BRIEF.md
# Short-Address Sequential DMA Channel

A single DMA channel that moves one data unit per activation between a stepping memory-side address and a fixed peripheral-side address. Each transfer is a bus read followed by a bus write. The memory address steps up or down by the unit size after every transfer, and the peripheral address never changes. A peripheral flag selected by a 4-bit source code starts each transfer. The channel can optionally pulse a clear back to that flag when it accepts the request.

Software sets up the addresses, count and control fields while the channel is off. It checks that the status register reads the run bit as 0, and then sets the run bit. When the count runs out, the channel turns itself off and raises an end flag. It drives an interrupt line only if the end interrupt is enabled.

Register map (`cfg_addr`):
- 0 is the memory address.
- 1 is the peripheral address.
- 2 is the remaining count.
- 3 is control.
- 4 is status.

Read data appears on `cfg_rdata` one cycle after `cfg_addr` is presented.

Top module: `seqdma_channel`

## Requirements
- R1: After synchronous reset, registers 0 to 4 read 0, `bus_req` is 0, `end_irq` is 0 and `trig_clr` is 0.
- R2: A transfer starts only when the run bit is 1, no transfer is in progress, and the selected source is active. Control bits [7:4] select the source: codes 0 to 8 pick `trig_flags[code]` (0 is the converter done flag, 1 is serial transmit empty, 2 is serial receive full, 3 to 8 are timer channels 0 to 5), code 9 picks `ext_req`, and codes 10 to 15 select nothing. An unselected flag starts nothing, and neither does any flag while the run bit is 0.
- R3: Each transfer is one read cycle followed by one write cycle. Control bit 2 sets the direction: with 0 the channel reads the memory address and writes the peripheral address; with 1 it does the reverse. `bus_req`, `bus_addr` and `bus_we` are held until `bus_rdy` is sampled high.
- R4: Control bit 0 sets the unit size: 0 is byte, 1 is 16-bit word. A byte transfer writes `{8'h00, rdata[7:0]}` and steps the memory address by 1. A word transfer writes all 16 bits and steps by 2.
- R5: Control bit 1 = 1 subtracts the step instead of adding it, and the result wraps modulo 2^24. The peripheral address register never changes.
- R6: The count decreases by one per completed transfer. On the transfer that takes it to 0, the run bit clears and the end flag (status bit 2) sets.
- R7: `end_irq` is high exactly when the end flag and the end interrupt enable (status bit 1) are both set, one cycle after they are.
- R8: With control bit 8 = 1, accepting a request on source code c in 0 to 8 pulses `trig_clr[c]` for one cycle. There is no pulse when bit 8 is 0, and none for code 9.
- R9: Writes to registers 0 to 3 are ignored while the run bit is 1. A write to register 4 sets the run bit from bit 0 and the interrupt enable from bit 1, and clears the end flag when bit 2 is 1.
- R10: If the final transfer completes in the same cycle as a write to register 4, the hardware clearing of the run bit and setting of the end flag take priority. The interrupt enable still takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data |
| trig_flags | input | 9 | Internal peripheral request flags |
| ext_req | input | 1 | External request line |
| trig_clr | output | 9 | One-cycle flag clear pulses |
| bus_req | output | 1 | Bus cycle request |
| bus_we | output | 1 | 1 for write cycle, 0 for read |
| bus_word | output | 1 | 1 for 16-bit cycle, 0 for byte |
| bus_addr | output | 24 | Bus address |
| bus_wdata | output | 16 | Bus write data |
| bus_rdata | input | 16 | Bus read data |
| bus_rdy | input | 1 | Cycle completion |
| end_irq | output | 1 | Transfer-end interrupt |

## Verification
Two functions can fall on the same edge: the completion of the last write cycle, and a software write to the status register. The bench holds the bus ready signal under manual control until the final write cycle is pending. It then raises ready and the status write (run, enable and flag-clear bits all 1) in the same cycle. The result is judged by reading status back. The run bit must be 0, the end flag 1 and the interrupt enable 1 (value 6), and the interrupt line must then be high.

// File: rtl/seqdma_pkg.sv
package seqdma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } eng_state_t;

  // control register layout, bit 8 down to bit 0
  typedef struct packed {
    logic       clr_en;
    logic [3:0] src;
    logic       gap;
    logic       io2mem;
    logic       dec;
    logic       word;
  } ctrl_t;

  localparam logic [2:0] REG_MADDR = 3'd0;
  localparam logic [2:0] REG_IOADR = 3'd1;
  localparam logic [2:0] REG_COUNT = 3'd2;
  localparam logic [2:0] REG_CTRL  = 3'd3;
  localparam logic [2:0] REG_STAT  = 3'd4;

endpackage

// File: rtl/seqdma_regs.sv
module seqdma_regs
  import seqdma_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16,
  parameter int RD_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [RD_W-1:0]   cfg_wdata,
  output logic [RD_W-1:0]   cfg_rdata,
  input  logic              xfer_done,
  output logic [ADDR_W-1:0] maddr,
  output logic [ADDR_W-1:0] ioaddr,
  output ctrl_t             ctrl,
  output logic              run,
  output logic              end_irq
);

  localparam int CTRL_W = $bits(ctrl_t);

  logic [ADDR_W-1:0] maddr_q, ioaddr_q, maddr_nx;
  logic [CNT_W-1:0]  cnt_q;
  ctrl_t             ctrl_q;
  logic              run_q, ie_q, flag_q, irq_q;
  logic [ADDR_W-1:0] step;
  logic              unused_wbits;

  assign unused_wbits = ^cfg_wdata[RD_W-1:ADDR_W];

  assign step     = ctrl_q.word ? ADDR_W'(2) : ADDR_W'(1);
  assign maddr_nx = ctrl_q.dec ? (maddr_q - step) : (maddr_q + step);

  always_ff @(posedge clk) begin
    if (rst) begin
      maddr_q  <= '0;
      ioaddr_q <= '0;
      cnt_q    <= '0;
      ctrl_q   <= '0;
      run_q    <= 1'b0;
      ie_q     <= 1'b0;
      flag_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      // configuration is frozen while the channel runs
      if (cfg_we && !run_q) begin
        case (cfg_addr)
          REG_MADDR: maddr_q  <= cfg_wdata[ADDR_W-1:0];
          REG_IOADR: ioaddr_q <= cfg_wdata[ADDR_W-1:0];
          REG_COUNT: cnt_q    <= cfg_wdata[CNT_W-1:0];
          REG_CTRL:  ctrl_q   <= ctrl_t'(cfg_wdata[CTRL_W-1:0]);
          default: ;
        endcase
      end
      if (cfg_we && cfg_addr == REG_STAT) begin
        run_q <= cfg_wdata[0];
        ie_q  <= cfg_wdata[1];
        if (cfg_wdata[2]) flag_q <= 1'b0;
      end
      // completion comes last so it wins over a same-cycle status write
      if (xfer_done) begin
        maddr_q <= maddr_nx;
        cnt_q   <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) begin
          run_q  <= 1'b0;
          flag_q <= 1'b1;
        end
      end
      irq_q <= flag_q & ie_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata <= '0;
    end else begin
      case (cfg_addr)
        REG_MADDR: cfg_rdata <= RD_W'(maddr_q);
        REG_IOADR: cfg_rdata <= RD_W'(ioaddr_q);
        REG_COUNT: cfg_rdata <= RD_W'(cnt_q);
        REG_CTRL:  cfg_rdata <= RD_W'(ctrl_q);
        REG_STAT:  cfg_rdata <= RD_W'({flag_q, ie_q, run_q});
        default:   cfg_rdata <= '0;
      endcase
    end
  end

  assign maddr   = maddr_q;
  assign ioaddr  = ioaddr_q;
  assign ctrl    = ctrl_q;
  assign run     = run_q;
  assign end_irq = irq_q;

  // R6: the last completion turns the channel off and sets the end flag
  a_r6_last_stops: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && cnt_q == CNT_W'(1)) |=> (!run_q && flag_q));

  // R9: while running, the peripheral address never changes
  a_r9_io_frozen: assert property (@(posedge clk) disable iff (rst)
    run_q |=> $stable(ioaddr_q));

  // R9: while running, the memory address moves only on a completion
  a_r9_maddr_frozen: assert property (@(posedge clk) disable iff (rst)
    (run_q && !xfer_done) |=> $stable(maddr_q));

endmodule

// File: rtl/seqdma_trig_sel.sv
module seqdma_trig_sel #(
  parameter int NUM_INT = 9,
  parameter int SEL_W   = 4,
  parameter bit EXT_OK  = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_INT-1:0] flags,
  input  logic               ext_req,
  input  logic [SEL_W-1:0]   sel,
  input  logic               clr_en,
  input  logic               accept,
  output logic               req,
  output logic [NUM_INT-1:0] trig_clr
);

  logic [NUM_INT-1:0] sel_is;
  logic               ext_hit;
  logic [NUM_INT-1:0] clr_q;

  for (genvar i = 0; i < NUM_INT; i++) begin : g_src
    assign sel_is[i] = (sel == SEL_W'(i));
  end

  assign ext_hit = EXT_OK && (sel == SEL_W'(NUM_INT)) && ext_req;
  assign req     = (|(sel_is & flags)) | ext_hit;

  always_ff @(posedge clk) begin
    if (rst) clr_q <= '0;
    else     clr_q <= (accept && clr_en) ? sel_is : '0;
  end

  assign trig_clr = clr_q;

  // R8: at most one flag is cleared at a time
  a_r8_one_clear: assert property (@(posedge clk) disable iff (rst)
    $onehot0(clr_q));

  // R8: a clear is a single-cycle pulse
  a_r8_pulse_len: assert property (@(posedge clk) disable iff (rst)
    (|clr_q) |=> !(|clr_q));

endmodule

// File: rtl/seqdma_engine.sv
module seqdma_engine
  import seqdma_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [ADDR_W-1:0] maddr,
  input  logic [ADDR_W-1:0] ioaddr,
  input  logic              word,
  input  logic              io2mem,
  output logic              bus_req,
  output logic              bus_we,
  output logic              bus_word,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_rdy,
  output logic              accept,
  output logic              xfer_done
);

  eng_state_t        state;
  logic [DATA_W-1:0] rd_fmt;

  assign rd_fmt    = bus_word ? bus_rdata : {{(DATA_W-8){1'b0}}, bus_rdata[7:0]};
  assign accept    = (state == ST_IDLE) && go;
  assign xfer_done = (state == ST_WRITE) && bus_rdy;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_word  <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      case (state)
        ST_IDLE: if (go) begin
          state    <= ST_READ;
          bus_req  <= 1'b1;
          bus_we   <= 1'b0;
          bus_word <= word;
          bus_addr <= io2mem ? ioaddr : maddr;
        end
        ST_READ: if (bus_rdy) begin
          state     <= ST_WRITE;
          bus_we    <= 1'b1;
          bus_addr  <= io2mem ? maddr : ioaddr;
          bus_wdata <= rd_fmt;
        end
        ST_WRITE: if (bus_rdy) begin
          state   <= ST_IDLE;
          bus_req <= 1'b0;
          bus_we  <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: a pending cycle keeps its request, address and direction until ready
  a_r3_hold_until_rdy: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_rdy) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

  // R3: every transfer opens with a read cycle
  a_r3_read_first: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req) |-> !bus_we);

endmodule

// File: rtl/seqdma_channel.sv
module seqdma_channel
  import seqdma_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 16,
  parameter int NUM_INT = 9,
  parameter bit EXT_OK  = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_addr,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  input  logic [NUM_INT-1:0] trig_flags,
  input  logic               ext_req,
  output logic [NUM_INT-1:0] trig_clr,
  output logic               bus_req,
  output logic               bus_we,
  output logic               bus_word,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic [DATA_W-1:0]  bus_wdata,
  input  logic [DATA_W-1:0]  bus_rdata,
  input  logic               bus_rdy,
  output logic               end_irq
);

  localparam int SEL_W = 4;

  logic [ADDR_W-1:0] maddr, ioaddr;
  ctrl_t             ctrl;
  logic              run, req, accept, xfer_done;
  logic              unused_gap;

  assign unused_gap = ctrl.gap;

  seqdma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .RD_W(32)) u_regs (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .xfer_done(xfer_done),
    .maddr(maddr), .ioaddr(ioaddr), .ctrl(ctrl), .run(run), .end_irq(end_irq)
  );

  seqdma_trig_sel #(.NUM_INT(NUM_INT), .SEL_W(SEL_W), .EXT_OK(EXT_OK)) u_trig (
    .clk(clk), .rst(rst),
    .flags(trig_flags), .ext_req(ext_req), .sel(ctrl.src), .clr_en(ctrl.clr_en),
    .accept(accept), .req(req), .trig_clr(trig_clr)
  );

  seqdma_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_eng (
    .clk(clk), .rst(rst),
    .go(run && req), .maddr(maddr), .ioaddr(ioaddr),
    .word(ctrl.word), .io2mem(ctrl.io2mem),
    .bus_req(bus_req), .bus_we(bus_we), .bus_word(bus_word), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rdy(bus_rdy),
    .accept(accept), .xfer_done(xfer_done)
  );

endmodule

// File: tb/seqdma_channel_bench.sv
`timescale 1ns/1ps
module seqdma_channel_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [8:0]  flags = '0;
  logic        ext_req = 1'b0;
  logic [8:0]  trig_clr;
  logic        bus_req, bus_we, bus_word, end_irq;
  logic [23:0] bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata = '0;
  logic        bus_rdy = 1'b0;

  int checks = 0, failures = 0;
  int rd_seen = 0, wr_seen = 0;
  bit auto_rdy = 1'b1, done = 1'b0;
  logic [23:0] ra [64];
  logic [23:0] wa [64];
  logic [15:0] wd [64];

  always #2.5 clk = ~clk;

  seqdma_channel u_seqdma_channel (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .trig_flags(flags), .ext_req(ext_req), .trig_clr(trig_clr),
    .bus_req(bus_req), .bus_we(bus_we), .bus_word(bus_word), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rdy(bus_rdy), .end_irq(end_irq)
  );

  function automatic logic [15:0] memval(input logic [23:0] a);
    return a[15:0] ^ 16'h5A3C;
  endfunction

  // bus slave and peripheral flag model, acting on the falling edge
  always @(negedge clk) begin
    flags = flags & ~trig_clr;
    if (auto_rdy) begin
      if (bus_rdy) bus_rdy = 1'b0;
      else if (bus_req) begin
        bus_rdy = 1'b1;
        if (bus_we) begin
          wa[wr_seen] = bus_addr; wd[wr_seen] = bus_wdata; wr_seen++;
        end else begin
          bus_rdata = memval(bus_addr); ra[rd_seen] = bus_addr; rd_seen++;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); cfg_addr = a;
    @(negedge clk); v = cfg_rdata;
  endtask

  typedef struct packed {
    logic [23:0] m;
    logic [23:0] io;
    logic [15:0] cnt;
    logic        word;
    logic        dec;
    logic        io2mem;
    logic [3:0]  src;
    logic        ie;
    logic [23:0] mfin;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{24'h001000, 24'h00FF20, 16'd3, 1'b0, 1'b0, 1'b0, 4'd0, 1'b1, 24'h001003},
    '{24'h002000, 24'h00FF40, 16'd4, 1'b1, 1'b1, 1'b1, 4'd5, 1'b0, 24'h001FF8},
    '{24'h003010, 24'h00FF60, 16'd2, 1'b1, 1'b0, 1'b0, 4'd9, 1'b1, 24'h003014},
    '{24'h000001, 24'h00FF80, 16'd2, 1'b0, 1'b1, 1'b1, 4'd8, 1'b0, 24'hFFFFFF}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int rb, wb;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    for (int r = 0; r < 5; r++) begin
      rd(3'(r), v); chk("R1 reg after reset", v, 0);
    end
    chk("R1 bus_req", bus_req, 0);
    chk("R1 end_irq", end_irq, 0);
    chk("R1 trig_clr", trig_clr, 0);

    // table walk: R3 R4 R5 R6 R7 R2 R8
    foreach (VECS[i]) begin
      vec_t t = VECS[i];
      wr(3'd4, 32'h4);
      rd(3'd4, v); chk("R9 run bit reads 0 before enable", v[0], 0);
      wr(3'd0, 32'(t.m));
      wr(3'd1, 32'(t.io));
      wr(3'd2, 32'(t.cnt));
      wr(3'd3, {23'd0, 1'b1, t.src, 1'b0, t.io2mem, t.dec, t.word});
      rb = rd_seen; wb = wr_seen;
      wr(3'd4, {30'd0, t.ie, 1'b1});
      for (int k = 0; k < int'(t.cnt); k++) begin
        if (t.src == 4'd9) ext_req = 1'b1; else flags[t.src] = 1'b1;
        wait (wr_seen == wb + k + 1);
        if (t.src == 4'd9) ext_req = 1'b0;
        else chk("R8 flag cleared on accept", flags[t.src], 0);
        repeat (3) @(negedge clk);
      end
      for (int k = 0; k < int'(t.cnt); k++) begin
        logic [23:0] st, mk, ea, eb;
        logic [15:0] ed;
        st = t.word ? 24'(2 * k) : 24'(k);
        mk = t.dec ? t.m - st : t.m + st;
        ea = t.io2mem ? t.io : mk;
        eb = t.io2mem ? mk : t.io;
        ed = t.word ? memval(ea) : {8'h00, memval(ea)[7:0]};
        chk("R3 read address", ra[rb + k], ea);
        chk("R3 write address", wa[wb + k], eb);
        chk("R4 write data", wd[wb + k], ed);
      end
      rd(3'd0, v); chk("R5 final memory address", v, t.mfin);
      rd(3'd1, v); chk("R5 io address unchanged", v, t.io);
      rd(3'd2, v); chk("R6 count at zero", v, 0);
      rd(3'd4, v); chk("R6 status after end", v, {29'd0, 1'b1, t.ie, 1'b0});
      chk("R7 end_irq follows enable", end_irq, t.ie);
      chk("R2 single transfer per request", wr_seen - wb, t.cnt);
    end

    // R7: clearing the flag drops the interrupt
    wr(3'd4, 32'h6);
    @(negedge clk);
    chk("R7 irq low after flag clear", end_irq, 0);

    // R2: unselected flag and disabled channel start nothing
    wr(3'd4, 32'h4);
    wr(3'd0, 32'h10); wr(3'd2, 32'd1); wr(3'd3, 32'h100);
    wr(3'd4, 32'h1);
    rb = rd_seen;
    flags[4] = 1'b1;
    repeat (10) @(negedge clk);
    chk("R2 unselected source ignored", rd_seen - rb, 0);
    flags[4] = 1'b0;
    wr(3'd4, 32'h0);
    flags[0] = 1'b1;
    repeat (10) @(negedge clk);
    chk("R2 disabled channel ignored", rd_seen - rb, 0);
    chk("R8 no clear without service", flags[0], 1);
    flags[0] = 1'b0;

    // R8 clear disabled, R9 frozen configuration
    wr(3'd0, 32'h400); wr(3'd1, 32'hFF00); wr(3'd2, 32'd2); wr(3'd3, 32'h020);
    wb = wr_seen;
    wr(3'd4, 32'h1);
    flags[2] = 1'b1;
    wait (wr_seen == wb + 1);
    chk("R8 flag kept when clear disabled", flags[2], 1);
    flags[2] = 1'b0;
    repeat (5) @(negedge clk);
    rd(3'd2, v); chk("R6 count after one transfer", v, 1);
    wr(3'd0, 32'h999);
    rd(3'd0, v); chk("R9 address write ignored while running", v, 32'h401);
    wr(3'd2, 32'd7);
    rd(3'd2, v); chk("R9 count write ignored while running", v, 1);
    wr(3'd4, 32'h0);

    // R10: final completion coincides with a status write
    auto_rdy = 1'b0;
    wr(3'd0, 32'h500); wr(3'd1, 32'hFF10); wr(3'd2, 32'd1); wr(3'd3, 32'h131);
    wr(3'd4, 32'h3);
    flags[3] = 1'b1;
    do @(negedge clk); while (!(bus_req && !bus_we));
    bus_rdata = 16'h1234; bus_rdy = 1'b1;
    @(negedge clk); bus_rdy = 1'b0;
    while (!(bus_req && bus_we)) @(negedge clk);
    chk("R4 word data before final write", bus_wdata, 16'h1234);
    bus_rdy = 1'b1; cfg_we = 1'b1; cfg_addr = 3'd4; cfg_wdata = 32'h7;
    @(negedge clk); bus_rdy = 1'b0; cfg_we = 1'b0;
    rd(3'd4, v); chk("R10 completion wins over status write", v, 6);
    chk("R10 irq raised", end_irq, 1);
    rd(3'd0, v); chk("R10 memory address stepped", v, 32'h502);
    auto_rdy = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule